// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a parameterised set of interrupt request lines (2 to 32) and drives two active-low requests toward a processor: a fast request and a normal request. Every source has an enable bit, a 3-bit priority, a sensing mode and a 32-bit vector word. Line 0 is the dedicated fast source. Any other line can be moved onto the fast output through a per-line force bit. All remaining enabled pending lines compete for the normal request through an eight-level resolver.

Software reaches the controller through an APB-style slave port. The register map is word aligned:

| Address | Contents |
|---|---|
| 0x000 + 4·n | Source configuration |
| 0x080 + 4·n | Vector word |
| 0x100 | Vector/acknowledge |
| 0x104 | End of interrupt |
| 0x108 | Enable set; reads back the enable mask |
| 0x10C | Enable clear |
| 0x110 | Edge clear |
| 0x114 | Fast force |
| 0x118 | Protect control |

A handler reads the vector word to learn which source won. That acknowledge pushes the winner's priority onto an eight-entry level stack. A write to the end-of-interrupt register pops the stack.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A source whose enable bit is 0 drives neither request. A 1 written to bit n at 0x108 sets enable n, and a 1 written to bit n at 0x10C clears it.
- R2: Line 0, when enabled and pending, drives `nfiq_o` low and never `nirq_o`. While only line 0 is pending, a vector read returns 0.
- R3: A 1 in bit n (n > 0) of the force register at 0x114 moves line n from `nirq_o` to `nfiq_o`. Clearing the bit moves it back. The register reads back its value.
- R4: The configuration word keeps the priority in bits [2:0]. Among normal candidates the highest priority wins, and on equal priority the lower line number wins. A read of 0x100 returns the winner's vector word.
- R5: Configuration bit 4 = 0 selects level sensing, where the line is pending while it is at its active level. Bit 5 inverts the active level, but only on lines marked external by `EXT_MASK`. Internal lines store bit 5 but ignore it.
- R6: With bit 4 = 1, an active-going edge sets a pending latch. Bit 5 selects the falling edge on external lines. The latch holds until the source is acknowledged or a 1 is written to its bit at 0x110.
- R7: With protect off, a read of 0x100 while `nirq_o` is low acknowledges the winner. It pushes the winner's priority and clears its edge latch. Afterwards `nirq_o` goes low only for a candidate of strictly higher priority than the top of the stack.
- R8: A write to 0x104 pops one stack entry (none when empty), restoring the previous in-service level.
- R9: With bit 0 of 0x118 set, reads of 0x100 return the vector with no side effect, and a write to 0x100 performs the acknowledge instead.
- R10: A read of 0x100 while `nirq_o` is high returns 0 and changes nothing.
- R11: After reset both requests are high and every enable, force, configuration and vector field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NSRC | Raw interrupt lines |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 10 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| nfiq_o | output | 1 | Active-low fast request |
| nirq_o | output | 1 | Active-low normal request |

## Verification
A corrupted level stack shows as `nirq_o` staying high after an end-of-interrupt, or going low for a source at the in-service level, within one cycle of the offending access. A stuck edge latch shows as a request that persists after acknowledge or clear. A wrong tie-break or a wrong vector index shows on the very next vector read. Routing faults between the fast and normal paths show on the two request pins in the same cycle the force or enable register changes.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int          NSRC     = 8,
  parameter logic [31:0] EXT_MASK = 32'h0000_00C0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_src,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [9:0]      paddr,
  input  logic [31:0]     pwdata,
  output logic [31:0]     prdata,
  output logic            nfiq_o,
  output logic            nirq_o
);
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int LVLS = 8;

  logic [2:0]      prio [NSRC];
  logic [31:0]     vec  [NSRC];
  logic [NSRC-1:0] edge_m, inv_m, en, frc, latch, prev;
  logic            prot;
  logic [2:0]      stk [LVLS];
  logic [3:0]      depth;

  logic [NSRC-1:0] pol, pend, act, fast, cand, rise, clr;
  logic            found;
  logic [2:0]      wpri, top;
  logic [IW-1:0]   widx;
  logic            raise;

  assign pol   = irq_src ^ (inv_m & EXT_MASK[NSRC-1:0]);
  assign pend  = (edge_m & latch) | (~edge_m & pol);
  assign act   = pend & en;
  assign fast  = frc | NSRC'(1);
  assign cand  = act & ~fast;
  assign rise  = pol & ~prev & edge_m;

  always_comb begin
    found = 1'b0;
    wpri  = '0;
    widx  = '0;
    for (int i = 0; i < NSRC; i++)
      if (cand[i] && (!found || prio[i] > wpri)) begin
        found = 1'b1;
        wpri  = prio[i];
        widx  = IW'(i);
      end
  end

  assign top    = stk[depth[2:0] - 3'd1];
  assign raise  = found && (depth == 4'd0 || wpri > top);
  assign nirq_o = ~raise;
  assign nfiq_o = ~|(act & fast);

  logic       acc, rd, wr, is_ctl, is_tbl, sel_ok, vec_acc, ack, eoi;
  logic [2:0] sub;
  logic [4:0] sidx;

  assign acc     = psel & penable & (paddr[1:0] == 2'b00) & ~paddr[9];
  assign rd      = acc & ~pwrite;
  assign wr      = acc & pwrite;
  assign is_ctl  = paddr[8] & (paddr[7:5] == 3'b000);
  assign is_tbl  = ~paddr[8];
  assign sub     = paddr[4:2];
  assign sidx    = paddr[6:2];
  assign sel_ok  = int'(sidx) < NSRC;
  assign vec_acc = acc && is_ctl && sub == 3'd0;
  assign ack     = raise && vec_acc && (pwrite == prot);
  assign eoi     = wr && is_ctl && sub == 3'd1;
  assign clr     = ((wr && is_ctl && sub == 3'd4) ? pwdata[NSRC-1:0] : '0)
                 | (ack ? (NSRC'(1) << widx) : '0);

  always_comb begin
    prdata = '0;
    if (is_tbl && sel_ok) begin
      if (paddr[7]) prdata = vec[sidx[IW-1:0]];
      else prdata = {26'd0, inv_m[sidx[IW-1:0]], edge_m[sidx[IW-1:0]], 1'b0, prio[sidx[IW-1:0]]};
    end else if (is_ctl) begin
      case (sub)
        3'd0:    prdata = raise ? vec[widx] : '0;
        3'd2:    prdata = 32'(en);
        3'd5:    prdata = 32'(frc);
        3'd6:    prdata = {31'd0, prot};
        default: prdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        prio[i] <= '0;
        vec[i]  <= '0;
      end
      for (int k = 0; k < LVLS; k++) stk[k] <= '0;
      edge_m <= '0;
      inv_m  <= '0;
      en     <= '0;
      frc    <= '0;
      latch  <= '0;
      prev   <= '1;
      prot   <= 1'b0;
      depth  <= '0;
    end else begin
      prev  <= pol;
      latch <= (latch & ~clr) | rise;
      if (wr && is_tbl && sel_ok) begin
        if (paddr[7]) vec[sidx[IW-1:0]] <= pwdata;
        else begin
          prio[sidx[IW-1:0]]   <= pwdata[2:0];
          edge_m[sidx[IW-1:0]] <= pwdata[4];
          inv_m[sidx[IW-1:0]]  <= pwdata[5];
        end
      end
      if (wr && is_ctl) begin
        case (sub)
          3'd2:    en   <= en | pwdata[NSRC-1:0];
          3'd3:    en   <= en & ~pwdata[NSRC-1:0];
          3'd5:    frc  <= pwdata[NSRC-1:0] & ~NSRC'(1);
          3'd6:    prot <= pwdata[0];
          default: ;
        endcase
      end
      if (ack) begin
        stk[depth[2:0]] <= wpri;
        depth           <= depth + 4'd1;
      end else if (eoi && depth != 4'd0) begin
        depth <= depth - 4'd1;
      end
    end
  end

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= 4'd8); // R7
  AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> depth == $past(depth) + 4'd1); // R7
  AST_EOI_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && depth != 4'd0) |=> depth == $past(depth) - 4'd1); // R8
  AST_PROTECT_READ_PURE: assert property (@(posedge clk) disable iff (!rst_n)
    (prot && rd && vec_acc) |=> $stable(depth)); // R9
  AST_FAST_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
    (en[0] && pend[0]) |-> !nfiq_o); // R2
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |-> (nirq_o && nfiq_o)); // R1
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  localparam int NSRC = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] irq_src = '0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [9:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic nfiq_o, nirq_o;

  irq_vector_ctrl #(.NSRC(NSRC)) i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .nfiq_o(nfiq_o), .nirq_o(nirq_o));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    if (psel && penable && !pwrite) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read got=%h exp=none", prdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (prdata !== e) begin
          fails++;
          $display("FAIL %s read got=%h exp=%h", t, prdata, e);
        end
      end
    end
  end

  task automatic bus(input logic w, input logic [9:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus(1'b1, a, d);
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus(1'b0, a, '0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pins(input logic ef, input logic ei, input string t);
    @(negedge clk);
    checks++;
    if (nfiq_o !== ef || nirq_o !== ei) begin
      fails++;
      $display("FAIL %s pins got fiq=%b irq=%b exp fiq=%b irq=%b", t, nfiq_o, nirq_o, ef, ei);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog got=timeout exp=completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    pins(1, 1, "R11");
    rd(10'h108, 0, "R11");
    rd(10'h084, 0, "R11");
    for (int i = 0; i < NSRC; i++) wr(10'(10'h080 + 4 * i), 32'h1000 + i);
    rd(10'h094, 32'h1005, "R4");

    // R1 enable mask
    wr(10'h008, 32'h1);
    irq_src[2] = 1'b1; idle(2);
    pins(1, 1, "R1");
    wr(10'h108, 32'h4);
    pins(1, 0, "R1");
    rd(10'h108, 32'h4, "R1");
    wr(10'h10C, 32'h4);
    pins(1, 1, "R1");
    // R5 level sensing and polarity
    wr(10'h108, 32'h4);
    pins(1, 0, "R5");
    irq_src[2] = 1'b0; idle(2);
    pins(1, 1, "R5");
    wr(10'h10C, 32'h4);
    wr(10'h018, 32'h21);
    wr(10'h108, 32'h40);
    pins(1, 0, "R5");
    irq_src[6] = 1'b1; idle(2);
    pins(1, 1, "R5");
    wr(10'h10C, 32'h40);
    wr(10'h00C, 32'h21);
    wr(10'h108, 32'h8);
    pins(1, 1, "R5");
    irq_src[3] = 1'b1; idle(2);
    pins(1, 0, "R5");
    rd(10'h00C, 32'h21, "R5");
    irq_src[3] = 1'b0;
    wr(10'h10C, 32'h8);
    irq_src[6] = 1'b0;

    // R4 R7 R8 R10 priority, ties, stack
    wr(10'h010, 32'h5);
    wr(10'h014, 32'h5);
    irq_src[2] = 1'b1; irq_src[4] = 1'b1; irq_src[5] = 1'b1;
    wr(10'h108, 32'h34);
    pins(1, 0, "R4");
    rd(10'h100, 32'h1004, "R4");
    pins(1, 1, "R7");
    rd(10'h100, 32'h0, "R10");
    pins(1, 1, "R10");
    wr(10'h104, 0);
    pins(1, 0, "R8");
    rd(10'h100, 32'h1004, "R4");
    wr(10'h004, 32'h7);
    irq_src[1] = 1'b1;
    wr(10'h108, 32'h2);
    pins(1, 0, "R7");
    rd(10'h100, 32'h1001, "R7");
    pins(1, 1, "R7");
    wr(10'h104, 0);
    pins(1, 0, "R8");
    rd(10'h100, 32'h1001, "R8");
    repeat (3) wr(10'h104, 0);
    pins(1, 0, "R8");
    rd(10'h100, 32'h1001, "R8");
    wr(10'h104, 0);
    wr(10'h10C, 32'hFF);
    irq_src = '0; idle(2);
    pins(1, 1, "R1");

    // R6 edge latches
    wr(10'h00C, 32'h12);
    wr(10'h108, 32'h8);
    irq_src[3] = 1'b1; idle(1); irq_src[3] = 1'b0; idle(2);
    pins(1, 0, "R6");
    idle(3);
    pins(1, 0, "R6");
    wr(10'h110, 32'h8);
    pins(1, 1, "R6");
    irq_src[3] = 1'b1; idle(1); irq_src[3] = 1'b0; idle(2);
    pins(1, 0, "R6");
    rd(10'h100, 32'h1003, "R6");
    wr(10'h104, 0);
    pins(1, 1, "R6");
    wr(10'h10C, 32'h8);
    irq_src[7] = 1'b1; idle(2);
    wr(10'h01C, 32'h32);
    wr(10'h108, 32'h80);
    pins(1, 1, "R6");
    irq_src[7] = 1'b0; idle(2);
    pins(1, 0, "R6");
    rd(10'h100, 32'h1007, "R6");
    wr(10'h104, 0);
    pins(1, 1, "R6");
    wr(10'h10C, 32'h80);

    // R2 fast line 0
    wr(10'h000, 32'h7);
    irq_src[0] = 1'b1;
    wr(10'h108, 32'h1);
    pins(0, 1, "R2");
    rd(10'h100, 32'h0, "R2");
    wr(10'h10C, 32'h1);
    irq_src[0] = 1'b0; idle(2);
    pins(1, 1, "R2");

    // R3 fast forcing
    wr(10'h008, 32'h3);
    irq_src[2] = 1'b1;
    wr(10'h108, 32'h4);
    pins(1, 0, "R3");
    wr(10'h114, 32'h4);
    pins(0, 1, "R3");
    rd(10'h114, 32'h4, "R3");
    wr(10'h114, 32'h0);
    pins(1, 0, "R3");

    // R9 protect mode
    wr(10'h118, 32'h1);
    rd(10'h100, 32'h1002, "R9");
    pins(1, 0, "R9");
    rd(10'h100, 32'h1002, "R9");
    wr(10'h100, 32'h0);
    pins(1, 1, "R9");
    wr(10'h104, 0);
    pins(1, 0, "R9");
    wr(10'h118, 32'h0);

    idle(2);
    if (exp_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard leftover got=%0d exp=0", exp_q.size());
    end
    finish_run();
  end
endmodule